// File: doc/BRIEF.md
# Cost-Aware Recency Replacement for One Cache Set

This block holds the replacement state of one set in an eight-way shared last-level cache placed in front of a main memory made of a DRAM region and a non-volatile region. Tag compare, data storage and memory control live elsewhere. The surrounding cache logic tells the block about each access: whether it is a fill or a hit, which way is involved, whether the line is written, and its physical address. From this the block updates its per-way valid and dirty flags and its recency stack.

The recency stack is a set of per-way position counters. Position 0 is the most protected slot and position 7 is the next to be replaced. A plain recency policy always moves the touched way to slot 0. Here the touched way goes to a slot chosen by what it would cost to lose the line before it is reused. A line that must later be written back to the slow non-volatile region is the most protected. A clean line from the same region ranks below it, and DRAM lines rank lower again. The victim for the next miss is always shown on the outputs, together with a flag that says whether that victim needs a write-back.

Top module: `cost_lru_set`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears every valid and dirty flag and puts way i at stack position i, so victim_way is 0 and victim_dirty is 0.
- R2: An address a is in the non-volatile region when NVM_BASE <= a <= NVM_LIMIT, with both ends included (defaults 0x8000_0000 and 0xBFFF_FFFF). Every other address is DRAM.
- R3: The target slot depends on the line's region and on its dirty status after the access. Dirty non-volatile lines go to slot 0, clean non-volatile lines to slot 2, dirty DRAM lines to slot 4 and clean DRAM lines to slot 5.
- R4: A fill (req_valid=1, req_fill=1) marks the way valid, sets its dirty flag to req_dirty and moves the way to its target slot.
- R5: When the target slot t is smaller than the way's old slot o, every other way whose slot s satisfies t <= s < o moves one slot toward 7.
- R6: When t is larger than o, every other way whose slot s satisfies o < s <= t moves one slot toward 0. When t equals o, the other ways do not move.
- R7: On a hit (req_fill=0), the new dirty flag is the old flag OR req_dirty, and the target slot uses that new flag. A read hit never clears dirty.
- R8: While any way is invalid, victim_way is the lowest-indexed invalid way and victim_dirty is 0.
- R9: While all ways are valid, victim_way is the way at slot 7 and victim_dirty is that way's dirty flag. Both are combinational from the stored state.
- R10: The eight slot counters always form a permutation of 0..7.
- R11: A cycle with req_valid=0 (and rst=0) leaves the slots, valid flags and dirty flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access update this cycle |
| req_fill | input | 1 | 1 = fill of a new line, 0 = hit |
| req_way | input | 3 | Way being filled or hit |
| req_dirty | input | 1 | Access writes the line (fill of a dirty line or write hit) |
| req_addr | input | 32 | Physical address of the line |
| victim_way | output | 3 | Way to replace on the next miss |
| victim_dirty | output | 1 | Victim holds a valid dirty line |
| stack_pos | output | 24 | Slot of way i in bits [3i+2:3i] |
| line_valid | output | 8 | Per-way valid flags |
| line_dirty | output | 8 | Per-way dirty flags |

## Verification
An access presented in one cycle changes stack_pos, line_valid and line_dirty at the next rising edge. The victim outputs follow combinationally from that new state, so every result of a request is due one edge after it is driven. The driver applies each request on a falling edge and queues the state it predicts after that request. The monitor samples one nanosecond after the next rising edge and compares all outputs, so each queued entry lines up with exactly one edge. Idle cycles and resets are queued the same way, which checks that nothing moves when no request is given.

// File: rtl/cost_lru_pkg.sv
package cost_lru_pkg;

  typedef enum logic [1:0] {
    CL_NV_DIRTY = 2'd0,
    CL_NV_CLEAN = 2'd1,
    CL_DR_DIRTY = 2'd2,
    CL_DR_CLEAN = 2'd3
  } cost_class_e;

  function automatic cost_class_e classify(input logic is_nv, input logic dirty);
    if (is_nv) return dirty ? CL_NV_DIRTY : CL_NV_CLEAN;
    else       return dirty ? CL_DR_DIRTY : CL_DR_CLEAN;
  endfunction

endpackage

// File: rtl/clp_region.sv
module clp_region #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] NVM_BASE  = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] NVM_LIMIT = 32'hBFFF_FFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_nv
);
  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    return (a >= NVM_BASE) && (a <= NVM_LIMIT);
  endfunction

  assign is_nv = in_window(addr);
endmodule

// File: rtl/clp_target.sv
module clp_target
  import cost_lru_pkg::*;
#(
  parameter int POS_W = 3,
  parameter logic [POS_W-1:0] P_NV_DIRTY = 3'd0,
  parameter logic [POS_W-1:0] P_NV_CLEAN = 3'd2,
  parameter logic [POS_W-1:0] P_DR_DIRTY = 3'd4,
  parameter logic [POS_W-1:0] P_DR_CLEAN = 3'd5
) (
  input  logic             is_nv,
  input  logic             dirty,
  output logic [POS_W-1:0] tgt
);
  function automatic logic [POS_W-1:0] slot_for(input cost_class_e c);
    case (c)
      CL_NV_DIRTY: return P_NV_DIRTY;
      CL_NV_CLEAN: return P_NV_CLEAN;
      CL_DR_DIRTY: return P_DR_DIRTY;
      default:     return P_DR_CLEAN;
    endcase
  endfunction

  assign tgt = slot_for(classify(is_nv, dirty));
endmodule

// File: rtl/clp_stack_move.sv
module clp_stack_move #(
  parameter int WAYS  = 8,
  parameter int POS_W = $clog2(WAYS),
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS*POS_W-1:0] cur_pos,
  input  logic [WAY_W-1:0]      sel_way,
  input  logic [POS_W-1:0]      tgt,
  output logic [WAYS*POS_W-1:0] nxt_pos
);
  logic [POS_W-1:0] old_sel;

  assign old_sel = cur_pos[sel_way*POS_W +: POS_W];

  // New slot of one way when the selected way moves from o to t.
  function automatic logic [POS_W-1:0] slot_next(
    input logic [POS_W-1:0] s,
    input logic [POS_W-1:0] o,
    input logic [POS_W-1:0] t,
    input logic             is_sel
  );
    if (is_sel)                          return t;
    else if (t < o && s >= t && s < o)   return s + 1'b1;
    else if (t > o && s > o && s <= t)   return s - 1'b1;
    else                                 return s;
  endfunction

  for (genvar i = 0; i < WAYS; i++) begin : g_way
    assign nxt_pos[i*POS_W +: POS_W] =
      slot_next(cur_pos[i*POS_W +: POS_W], old_sel, tgt, sel_way == WAY_W'(i));
  end
endmodule

// File: rtl/clp_victim.sv
module clp_victim #(
  parameter int WAYS  = 8,
  parameter int POS_W = $clog2(WAYS),
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS*POS_W-1:0] pos,
  input  logic [WAYS-1:0]       valid,
  input  logic [WAYS-1:0]       dirty,
  output logic [WAY_W-1:0]      victim_way,
  output logic                  victim_dirty,
  output logic                  any_invalid
);
  localparam logic [POS_W-1:0] LAST = POS_W'(WAYS - 1);

  logic [WAY_W-1:0] inv_way;
  logic [WAY_W-1:0] lru_way;

  always_comb begin
    inv_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid[i]) inv_way = WAY_W'(i);
    end
  end

  always_comb begin
    lru_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (pos[i*POS_W +: POS_W] == LAST) lru_way = WAY_W'(i);
    end
  end

  assign any_invalid  = ~&valid;
  assign victim_way   = any_invalid ? inv_way : lru_way;
  assign victim_dirty = valid[victim_way] & dirty[victim_way];
endmodule

// File: rtl/cost_lru_set.sv
module cost_lru_set
  import cost_lru_pkg::*;
#(
  parameter int WAYS   = 8,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] NVM_BASE  = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] NVM_LIMIT = 32'hBFFF_FFFF,
  parameter int POS_W  = $clog2(WAYS),
  parameter logic [POS_W-1:0] P_NV_DIRTY = 3'd0,
  parameter logic [POS_W-1:0] P_NV_CLEAN = 3'd2,
  parameter logic [POS_W-1:0] P_DR_DIRTY = 3'd4,
  parameter logic [POS_W-1:0] P_DR_CLEAN = 3'd5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_fill,
  input  logic [$clog2(WAYS)-1:0] req_way,
  input  logic                  req_dirty,
  input  logic [ADDR_W-1:0]     req_addr,
  output logic [$clog2(WAYS)-1:0] victim_way,
  output logic                  victim_dirty,
  output logic [WAYS*POS_W-1:0] stack_pos,
  output logic [WAYS-1:0]       line_valid,
  output logic [WAYS-1:0]       line_dirty
);
  localparam int WAY_W = $clog2(WAYS);

  function automatic logic [WAYS*POS_W-1:0] reset_order();
    logic [WAYS*POS_W-1:0] v;
    for (int i = 0; i < WAYS; i++) v[i*POS_W +: POS_W] = POS_W'(i);
    return v;
  endfunction

  logic [WAYS*POS_W-1:0] pos_q;
  logic [WAYS-1:0]       valid_q;
  logic [WAYS-1:0]       dirty_q;

  // Named events for the checker.
  logic                  upd_en;
  logic                  is_nv;
  logic                  upd_dirty;
  logic [POS_W-1:0]      tgt_pos;
  logic [WAYS*POS_W-1:0] nxt_pos;
  logic                  any_invalid;

  assign upd_en    = req_valid & ~rst;
  assign upd_dirty = req_fill ? req_dirty : (dirty_q[req_way] | req_dirty);

  clp_region #(
    .ADDR_W(ADDR_W), .NVM_BASE(NVM_BASE), .NVM_LIMIT(NVM_LIMIT)
  ) u_region (
    .addr (req_addr),
    .is_nv(is_nv)
  );

  clp_target #(
    .POS_W(POS_W), .P_NV_DIRTY(P_NV_DIRTY), .P_NV_CLEAN(P_NV_CLEAN),
    .P_DR_DIRTY(P_DR_DIRTY), .P_DR_CLEAN(P_DR_CLEAN)
  ) u_target (
    .is_nv(is_nv),
    .dirty(upd_dirty),
    .tgt  (tgt_pos)
  );

  clp_stack_move #(.WAYS(WAYS), .POS_W(POS_W), .WAY_W(WAY_W)) u_move (
    .cur_pos(pos_q),
    .sel_way(req_way),
    .tgt    (tgt_pos),
    .nxt_pos(nxt_pos)
  );

  clp_victim #(.WAYS(WAYS), .POS_W(POS_W), .WAY_W(WAY_W)) u_victim (
    .pos         (pos_q),
    .valid       (valid_q),
    .dirty       (dirty_q),
    .victim_way  (victim_way),
    .victim_dirty(victim_dirty),
    .any_invalid (any_invalid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= reset_order();
      valid_q <= '0;
      dirty_q <= '0;
    end else if (upd_en) begin
      pos_q            <= nxt_pos;
      valid_q[req_way] <= 1'b1;
      dirty_q[req_way] <= upd_dirty;
    end
  end

  assign stack_pos  = pos_q;
  assign line_valid = valid_q;
  assign line_dirty = dirty_q;
endmodule

// File: rtl/cost_lru_chk.sv
module cost_lru_chk #(
  parameter int WAYS  = 8,
  parameter int POS_W = $clog2(WAYS),
  parameter int WAY_W = $clog2(WAYS)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  req_fill,
  input logic                  req_dirty,
  input logic [WAY_W-1:0]      req_way,
  input logic [POS_W-1:0]      tgt_pos,
  input logic                  any_invalid,
  input logic [WAYS*POS_W-1:0] stack_pos,
  input logic [WAYS-1:0]       line_valid,
  input logic [WAYS-1:0]       line_dirty,
  input logic [WAY_W-1:0]      victim_way,
  input logic                  victim_dirty
);
  localparam logic [POS_W-1:0] LAST = POS_W'(WAYS - 1);

  function automatic logic [POS_W-1:0] slot_of(input logic [WAYS*POS_W-1:0] v, input int w);
    return v[w*POS_W +: POS_W];
  endfunction

  function automatic logic [WAYS*POS_W-1:0] ident();
    logic [WAYS*POS_W-1:0] v;
    for (int i = 0; i < WAYS; i++) v[i*POS_W +: POS_W] = POS_W'(i);
    return v;
  endfunction

  logic [WAY_W-1:0] way_d;
  logic [POS_W-1:0] tgt_d;
  logic [WAYS-1:0]  seen;

  always_ff @(posedge clk) begin
    way_d <= req_way;
    tgt_d <= tgt_pos;
  end

  always_comb begin
    seen = '0;
    for (int i = 0; i < WAYS; i++) seen[slot_of(stack_pos, i)] = 1'b1;
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (line_valid == '0 && line_dirty == '0 && stack_pos == ident()));

  p_way_at_target_r3: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> slot_of(stack_pos, int'(way_d)) == tgt_d);

  p_fill_sets_valid_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_fill) |=> line_valid[way_d]);

  p_fill_clean_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_fill && !req_dirty) |=> !line_dirty[way_d]);

  p_write_marks_dirty_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_dirty) |=> line_dirty[way_d]);

  p_read_hit_keeps_dirty_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_fill && line_dirty[req_way]) |=> line_dirty[way_d]);

  p_victim_invalid_r8: assert property (@(posedge clk) disable iff (rst)
    any_invalid |-> (!line_valid[victim_way] && !victim_dirty));

  p_victim_lru_r9: assert property (@(posedge clk) disable iff (rst)
    (&line_valid) |-> slot_of(stack_pos, int'(victim_way)) == LAST);

  p_victim_dirty_r9: assert property (@(posedge clk) disable iff (rst)
    victim_dirty |-> (line_valid[victim_way] && line_dirty[victim_way]));

  p_permutation_r10: assert property (@(posedge clk) disable iff (rst)
    &seen);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(stack_pos) && $stable(line_valid) && $stable(line_dirty)));
endmodule

bind cost_lru_set cost_lru_chk #(.WAYS(WAYS), .POS_W(POS_W), .WAY_W(WAY_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_fill    (req_fill),
  .req_dirty   (req_dirty),
  .req_way     (req_way),
  .tgt_pos     (tgt_pos),
  .any_invalid (any_invalid),
  .stack_pos   (stack_pos),
  .line_valid  (line_valid),
  .line_dirty  (line_dirty),
  .victim_way  (victim_way),
  .victim_dirty(victim_dirty)
);

// File: tb/sim_cost_lru_set.sv
module sim_cost_lru_set;
  localparam logic [31:0] NV_LO = 32'h8000_0000;
  localparam logic [31:0] NV_HI = 32'hBFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_fill = 1'b0;
  logic [2:0]  req_way = '0;
  logic        req_dirty = 1'b0;
  logic [31:0] req_addr = '0;
  logic [2:0]  victim_way;
  logic        victim_dirty;
  logic [23:0] stack_pos;
  logic [7:0]  line_valid;
  logic [7:0]  line_dirty;

  always #2 clk = ~clk;

  cost_lru_set u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_fill(req_fill),
    .req_way(req_way), .req_dirty(req_dirty), .req_addr(req_addr),
    .victim_way(victim_way), .victim_dirty(victim_dirty),
    .stack_pos(stack_pos), .line_valid(line_valid), .line_dirty(line_dirty)
  );

  typedef struct {
    string       rq;
    logic [23:0] pos;
    logic [7:0]  vld;
    logic [7:0]  drt;
    logic [2:0]  vway;
    logic        vdirty;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   stim_done = 1'b0;
  bit   wd_hit = 1'b0;

  // Reference model: ordered list, slot 0 first.
  int  ord[8];
  bit  mv[8];
  bit  md[8];

  function automatic logic [23:0] model_pos();
    logic [23:0] v = '0;
    for (int p = 0; p < 8; p++) v[ord[p]*3 +: 3] = 3'(p);
    return v;
  endfunction

  function automatic int model_victim();
    for (int w = 0; w < 8; w++) if (!mv[w]) return w;
    return ord[7];
  endfunction

  function automatic int slot_in_model(input int w);
    for (int p = 0; p < 8; p++) if (ord[p] == w) return p;
    return -1;
  endfunction

  function automatic int cost_slot(input logic [31:0] a, input bit d);
    bit nv = (a >= NV_LO) && (a <= NV_HI);
    if (nv) return d ? 0 : 2;
    return d ? 4 : 5;
  endfunction

  task automatic push_exp(input string rq);
    exp_t e;
    int v = model_victim();
    e.rq = rq;
    e.pos = model_pos();
    for (int w = 0; w < 8; w++) begin
      e.vld[w] = mv[w];
      e.drt[w] = md[w];
    end
    e.vway = 3'(v);
    e.vdirty = mv[v] & md[v];
    q.push_back(e);
  endtask

  task automatic do_reset(input string rq);
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    for (int w = 0; w < 8; w++) begin ord[w] = w; mv[w] = 0; md[w] = 0; end
    push_exp(rq);
    @(negedge clk);
    rst = 1'b0;
    push_exp(rq);
  endtask

  task automatic do_req(input bit fill, input int way, input bit d,
                        input logic [31:0] a, input string rq);
    int k, t;
    bit nd;
    @(negedge clk);
    rst = 1'b0; req_valid = 1'b1; req_fill = fill;
    req_way = 3'(way); req_dirty = d; req_addr = a;
    nd = fill ? d : (md[way] | d);
    t = cost_slot(a, nd);
    k = slot_in_model(way);
    for (int p = k; p < 7; p++) ord[p] = ord[p+1];
    for (int p = 7; p > t; p--) ord[p] = ord[p-1];
    ord[t] = way;
    mv[way] = 1; md[way] = nd;
    push_exp(rq);
  endtask

  task automatic do_idle(input string rq);
    @(negedge clk);
    req_valid = 1'b0; rst = 1'b0;
    req_way = ~req_way; req_dirty = ~req_dirty; req_addr = ~req_addr;
    push_exp(rq);
  endtask

  task automatic fill_victim(input bit d, input logic [31:0] a, input string rq);
    do_req(1'b1, model_victim(), d, a, rq);
  endtask

  task automatic hit_slot(input int p, input bit d, input logic [31:0] a, input string rq);
    do_req(1'b0, ord[p], d, a, rq);
  endtask

  task automatic cmp(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // Monitor: one queued expectation per rising edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        cmp(e.rq, "stack_pos",    32'(stack_pos),    32'(e.pos));
        cmp(e.rq, "line_valid",   32'(line_valid),   32'(e.vld));
        cmp(e.rq, "line_dirty",   32'(line_dirty),   32'(e.drt));
        cmp(e.rq, "victim_way",   32'(victim_way),   32'(e.vway));
        cmp(e.rq, "victim_dirty", 32'(victim_dirty), 32'(e.vdirty));
      end
    end
  end

  // Driver.
  initial begin
    logic [15:0] lf = 16'hACE1;
    do_reset("R1");
    // Fills in invalid-way order (R8), covering both region ends (R2).
    fill_victim(1'b1, NV_LO,              "R2_R3_R4_R8");
    fill_victim(1'b0, NV_LO - 32'd1,      "R2_R3_R4_R8");
    fill_victim(1'b0, NV_HI,              "R2_R3_R4_R8");
    fill_victim(1'b1, NV_HI + 32'd1,      "R2_R3_R4_R8");
    fill_victim(1'b0, 32'h0000_1000,      "R3_R4_R5_R8");
    fill_victim(1'b1, 32'h9000_0000,      "R3_R4_R5_R8");
    fill_victim(1'b1, 32'h0000_0000,      "R3_R4_R5_R8");
    fill_victim(1'b0, 32'hA000_0000,      "R3_R4_R9_R10");
    do_idle("R11");
    do_idle("R11");
    do_idle("R11");
    hit_slot(0, 1'b0, 32'h0000_2000,      "R6");
    hit_slot(7, 1'b1, 32'h8800_0000,      "R5_R9");
    hit_slot(6, 1'b1, 32'h0000_3000,      "R7");
    hit_slot(4, 1'b0, 32'h0000_3000,      "R6_R7");
    hit_slot(5, 1'b0, 32'h0000_4000,      "R6");
    fill_victim(1'b1, 32'hBFFF_0000,      "R4_R9");
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[0])
        fill_victim(lf[1], {lf[3:2], lf[15:4], 16'h0}, "R4_R9_R10");
      else if (lf[1] && lf[2])
        do_idle("R11");
      else
        hit_slot(int'(lf[6:4]), lf[7], {lf[9:8], lf[15:10], 24'h0}, "R5_R6_R7_R10");
    end
    do_reset("R1");
    fill_victim(1'b0, 32'hC000_0000,      "R2_R8");
    do_idle("R11");
    @(negedge clk);
    req_valid = 1'b0;
    while (q.size() > 0) @(negedge clk);
    stim_done = 1'b1;
  end

  initial begin
    #(4 * 100000);
    wd_hit = 1'b1;
  end

  initial begin
    wait (stim_done || wd_hit);
    if (!stim_done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule